// File: doc/BRIEF.md
# Half-Duplex Command Flow Sequencer

This block is the host-side controller for one complete command exchange with a half-duplex device that sleeps between exchanges. A single `start` pulse makes it run the whole exchange: it wakes the device, asks for and checks the synchronisation byte, announces a command, and has an external framer send the command block. It then waits the programmed delays, polls for an early error code when the command is a long one, and collects the response block. If the response fails its CRC check, it asks for the same response again. Every exchange ends with the device being put back to sleep.

Tokens are requested one at a time on `tok_req`/`tok_kind` and are consumed by a line driver that pulses `tok_done`. Received single bytes arrive on `rx_valid`/`rx_byte`. The framer reports the command block as sent with `blk_done`, and reports a collected response block with `resp_done` and its CRC verdict. Delays are counted in clock cycles. The delay values, the short-command select and the retry limit are captured when the exchange starts.

Top module: `cmd_flow_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `tok_req`, `blk_go` and all four error flags are 0.
- R2: `tok_kind` codes are 0 wake, 1 transmit, 2 command, 3 sleep. A started exchange requests wake first and then transmit. Each request holds `tok_req` high with a stable `tok_kind` until `tok_done`.
- R3: After the first transmit, a received byte of 0x11 leads to a command token followed by `blk_go`. Any other byte sets `sync_err`, and the next token is sleep with no command token before it.
- R4: On a long command (`short_cmd`=0), the poll transmit request appears `parse_dly`+2 cycles after the `blk_done` cycle. A byte received in the poll window that follows sets `dev_err`, captures the byte in `err_byte`, and leads to sleep.
- R5: On a long command with no byte during the poll window, the response transmit request appears POLL_WIN+`exec_dly`+3 cycles after the poll token's `tok_done` cycle.
- R6: On a short command no poll is made, and the response transmit request appears `parse_dly`+`exec_dly`+2 cycles after the `blk_done` cycle.
- R7: A response with `resp_crc_ok`=0 makes the block request transmit again, up to `max_retry` extra times. The next failure beyond that sets `retry_err` and leads to sleep. A good response leads to sleep with no error flag.
- R8: If no expected byte or response arrives within RESP_TMO+2 cycles of the transmit token's `tok_done` cycle, sleep is requested at exactly that cycle and `tmo_err` is set.
- R9: Every exchange ends with a sleep token. In the cycle after its `tok_done`, `done` is high for one cycle with `busy` low. At most one error flag is set, and the flags hold until the next start.
- R10: Changing `short_cmd`, `parse_dly`, `exec_dly` or `max_retry` after the start pulse has no effect on the running exchange.
- R11: A `start` pulse while busy is ignored: no new exchange follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (taken only when idle) |
| short_cmd | input | 1 | 1 selects the short-command path |
| parse_dly | input | DW | Parse delay in cycles |
| exec_dly | input | DW | Execute delay in cycles |
| max_retry | input | RW | Maximum number of response re-requests |
| tok_req | output | 1 | Token request valid |
| tok_kind | output | 2 | Requested token: 0 wake, 1 transmit, 2 command, 3 sleep |
| tok_done | input | 1 | Requested token has been sent |
| rx_valid | input | 1 | Single received byte valid |
| rx_byte | input | 8 | Received byte |
| blk_go | output | 1 | Framer should send the command block |
| blk_done | input | 1 | Framer finished sending the command block |
| resp_done | input | 1 | Framer collected a response block |
| resp_crc_ok | input | 1 | CRC verdict for the collected response |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| dev_err | output | 1 | Device returned an error code at the poll |
| err_byte | output | 8 | Error code captured at the poll |
| sync_err | output | 1 | Wake synchronisation byte was wrong |
| retry_err | output | 1 | Response CRC retries exhausted |
| tmo_err | output | 1 | Expected reply never arrived |

## Verification
The bench sweeps every parse and execute delay from 0 to 3 on both the long and the short path, and measures the cycle gaps exactly. An off-by-one timer load, or a short path that still polls, would shift a transmit request by a cycle or add a stray token. The retry limit is driven at zero, at one, and with failures just below and just above it. A counter compared with the wrong bound would accept one resend too many or give up one too early. A wrong sync byte, a missing sync byte, a missing response, an early error code and a start pulse during an exchange each check that the block goes to sleep with exactly the right single flag and does not start a new exchange. Inputs are scrambled after every start, so a block that reads them live instead of using the captured values shows wrong delays.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h11;

  typedef enum logic [1:0] {
    TK_WAKE  = 2'd0,
    TK_XMIT  = 2'd1,
    TK_CMD   = 2'd2,
    TK_SLEEP = 2'd3
  } tok_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE, S_SYNC_TX, S_SYNC_WT, S_CMD, S_BLK, S_PARSE,
    S_POLL_TX, S_POLL_WT, S_EXEC, S_RESP_TX, S_RESP_WT, S_SLEEP
  } st_e;

  typedef enum logic [2:0] {
    FL_NONE, FL_DEV, FL_SYNC, FL_RETRY, FL_TMO
  } flag_e;
endpackage

// File: rtl/cfs_timer.sv
module cfs_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R5: a load takes the value presented with it
  p_load_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(val));

  // R6: counting proceeds one step per cycle toward zero
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/cfs_retry.sv
module cfs_retry #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_max
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (inc)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_max = (cnt_q == limit);

  // R7: the sequencer never asks for a resend once the limit is reached
  p_inc_below_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_max);
endmodule

// File: rtl/cmd_flow_seq.sv
module cmd_flow_seq
  import cfs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int RW       = 3,
  parameter int POLL_WIN = 4,
  parameter int RESP_TMO = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          short_cmd,
  input  logic [DW-1:0] parse_dly,
  input  logic [DW-1:0] exec_dly,
  input  logic [RW-1:0] max_retry,
  output logic          tok_req,
  output logic [1:0]    tok_kind,
  input  logic          tok_done,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          blk_go,
  input  logic          blk_done,
  input  logic          resp_done,
  input  logic          resp_crc_ok,
  output logic          busy,
  output logic          done,
  output logic          dev_err,
  output logic [7:0]    err_byte,
  output logic          sync_err,
  output logic          retry_err,
  output logic          tmo_err
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TW = imax(DW + 1, imax($clog2(RESP_TMO + 1), $clog2(POLL_WIN + 1)));

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  st_e           st_q, st_d;
  logic          sh_q;
  logic [DW-1:0] p_q, e_q;
  logic [RW-1:0] mr_q;
  logic          cfg_en;
  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          rc_clr, rc_inc, rc_max;
  flag_e         set_flag;
  logic          dev_q, sync_q, retry_q, tmo_q, done_q;
  logic [7:0]    eb_q;

  cfs_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_ld), .val(tmr_val), .zero(tmr_zero));

  cfs_retry #(.W(RW)) u_retry (
    .clk(clk), .rst_n(rst_n_s), .clr(rc_clr), .inc(rc_inc),
    .limit(mr_q), .at_max(rc_max));

  assign cfg_en = (st_q == S_IDLE) && start;

  always_comb begin
    st_d     = st_q;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    rc_clr   = 1'b0;
    rc_inc   = 1'b0;
    set_flag = FL_NONE;
    unique case (st_q)
      S_IDLE:    if (start) begin st_d = S_WAKE; rc_clr = 1'b1; end
      S_WAKE:    if (tok_done) st_d = S_SYNC_TX;
      S_SYNC_TX: if (tok_done) begin
                   st_d = S_SYNC_WT; tmr_ld = 1'b1; tmr_val = TW'(RESP_TMO);
                 end
      S_SYNC_WT: if (rx_valid) begin
                   if (rx_byte == SYNC_BYTE) st_d = S_CMD;
                   else begin st_d = S_SLEEP; set_flag = FL_SYNC; end
                 end else if (tmr_zero) begin
                   st_d = S_SLEEP; set_flag = FL_TMO;
                 end
      S_CMD:     if (tok_done) st_d = S_BLK;
      S_BLK:     if (blk_done) begin
                   tmr_ld = 1'b1;
                   if (sh_q) begin st_d = S_EXEC;  tmr_val = TW'(p_q) + TW'(e_q); end
                   else      begin st_d = S_PARSE; tmr_val = TW'(p_q); end
                 end
      S_PARSE:   if (tmr_zero) st_d = S_POLL_TX;
      S_POLL_TX: if (tok_done) begin
                   st_d = S_POLL_WT; tmr_ld = 1'b1; tmr_val = TW'(POLL_WIN);
                 end
      S_POLL_WT: if (rx_valid) begin
                   st_d = S_SLEEP; set_flag = FL_DEV;
                 end else if (tmr_zero) begin
                   st_d = S_EXEC; tmr_ld = 1'b1; tmr_val = TW'(e_q);
                 end
      S_EXEC:    if (tmr_zero) st_d = S_RESP_TX;
      S_RESP_TX: if (tok_done) begin
                   st_d = S_RESP_WT; tmr_ld = 1'b1; tmr_val = TW'(RESP_TMO);
                 end
      S_RESP_WT: if (resp_done) begin
                   if (resp_crc_ok)  st_d = S_SLEEP;
                   else if (rc_max) begin st_d = S_SLEEP; set_flag = FL_RETRY; end
                   else begin st_d = S_RESP_TX; rc_inc = 1'b1; end
                 end else if (tmr_zero) begin
                   st_d = S_SLEEP; set_flag = FL_TMO;
                 end
      S_SLEEP:   if (tok_done) st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= S_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sh_q <= 1'b0; p_q <= '0; e_q <= '0; mr_q <= '0;
    end else if (cfg_en) begin
      sh_q <= short_cmd; p_q <= parse_dly; e_q <= exec_dly; mr_q <= max_retry;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dev_q <= 1'b0; sync_q <= 1'b0; retry_q <= 1'b0; tmo_q <= 1'b0;
      eb_q  <= '0;   done_q <= 1'b0;
    end else begin
      done_q <= (st_q == S_SLEEP) && tok_done;
      if (cfg_en) begin
        dev_q <= 1'b0; sync_q <= 1'b0; retry_q <= 1'b0; tmo_q <= 1'b0;
      end else begin
        if (set_flag == FL_DEV)   dev_q   <= 1'b1;
        if (set_flag == FL_SYNC)  sync_q  <= 1'b1;
        if (set_flag == FL_RETRY) retry_q <= 1'b1;
        if (set_flag == FL_TMO)   tmo_q   <= 1'b1;
      end
      if (set_flag == FL_DEV) eb_q <= rx_byte;
    end
  end

  always_comb begin
    tok_req  = 1'b1;
    tok_kind = TK_XMIT;
    unique case (st_q)
      S_WAKE:                       tok_kind = TK_WAKE;
      S_CMD:                        tok_kind = TK_CMD;
      S_SLEEP:                      tok_kind = TK_SLEEP;
      S_SYNC_TX, S_POLL_TX, S_RESP_TX: tok_kind = TK_XMIT;
      default:                      tok_req  = 1'b0;
    endcase
  end

  assign blk_go    = (st_q == S_BLK);
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign dev_err   = dev_q;
  assign err_byte  = eb_q;
  assign sync_err  = sync_q;
  assign retry_err = retry_q;
  assign tmo_err   = tmo_q;

  // R2: a pending token request stays put until it is taken
  p_tok_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tok_req && !tok_done) |=> (tok_req && $stable(tok_kind)));

  // R3: the block is only handed to the framer after a command token
  p_blk_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(blk_go) |-> $past(tok_done && tok_kind == 2'd2));

  // R8: a timeout moves straight to a sleep request
  p_tmo_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tmo_err) |-> (tok_req && tok_kind == 2'd3));

  // R9: a single error class per exchange
  p_one_err_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({dev_err, sync_err, retry_err, tmo_err}));

  // R9: completion coincides with the block being idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy);
endmodule

// File: tb/cmd_flow_seq_bench.sv
module cmd_flow_seq_bench;
  localparam int DW = 8, RW = 3, POLL_WIN = 4, RESP_TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, short_cmd = 1'b0;
  logic [DW-1:0] parse_dly = '0, exec_dly = '0;
  logic [RW-1:0] max_retry = '0;
  logic tok_req, blk_go, busy, done, dev_err, sync_err, retry_err, tmo_err;
  logic [1:0] tok_kind;
  logic [7:0] err_byte;
  logic tok_done = 1'b0, rx_valid = 1'b0, blk_done = 1'b0;
  logic resp_done = 1'b0, resp_crc_ok = 1'b0;
  logic [7:0] rx_byte = '0;

  int cyc = 0, total = 0, bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_flow_seq #(.DW(DW), .RW(RW), .POLL_WIN(POLL_WIN), .RESP_TMO(RESP_TMO)) u_cmd_flow_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .short_cmd(short_cmd),
    .parse_dly(parse_dly), .exec_dly(exec_dly), .max_retry(max_retry),
    .tok_req(tok_req), .tok_kind(tok_kind), .tok_done(tok_done),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .blk_go(blk_go), .blk_done(blk_done),
    .resp_done(resp_done), .resp_crc_ok(resp_crc_ok), .busy(busy), .done(done),
    .dev_err(dev_err), .err_byte(err_byte), .sync_err(sync_err),
    .retry_err(retry_err), .tmo_err(tmo_err));

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_tok(output int k, output int t);
    int w = 0;
    while (!tok_req && w < 2000) begin tick; w++; end
    k = int'(tok_kind); t = cyc;
    tok_done = 1'b1; tick; tok_done = 1'b0;
  endtask

  // mode: 0 normal, 1 wrong sync byte, 2 no sync byte, 3 poll error, 4 no response
  task automatic run_txn(input bit sh, input int p, input int e, input int mode,
                         input int nfail, input int maxr, input bit poke);
    int k, t, tx, tb, tp, tr, nresp, fails, gap_ref, gap_exp, ef;
    bit go;
    go = 1'b1; gap_exp = -1; gap_ref = 0; ef = 0; nresp = 0;
    short_cmd = sh; parse_dly = DW'(p); exec_dly = DW'(e); max_retry = RW'(maxr);
    start = 1'b1; tick; start = 1'b0;
    short_cmd = ~sh; parse_dly = 8'hEE; exec_dly = 8'hDD; max_retry = ~RW'(maxr); // R10
    get_tok(k, t); chk("R2 wake first", k, 0);
    if (poke) begin start = 1'b1; tick; start = 1'b0; end // R11
    get_tok(k, t); chk("R2 transmit second", k, 1); tx = t;
    if (mode == 2) begin
      go = 1'b0; gap_ref = tx; gap_exp = RESP_TMO + 2; ef = 4;
    end else begin
      rx_valid = 1'b1; rx_byte = (mode == 1) ? 8'h5A : 8'h11; tick; rx_valid = 1'b0;
      if (mode == 1) begin go = 1'b0; ef = 2; end
    end
    if (go) begin
      get_tok(k, t); chk("R3 command token", k, 2);
      while (!blk_go) tick;
      blk_done = 1'b1; tb = cyc; tick; blk_done = 1'b0;
      if (!sh) begin
        get_tok(k, t); tp = t;
        chk("R4 poll transmit", k, 1); chk("R4 R10 parse gap", t - tb, p + 2);
        if (mode == 3) begin
          rx_valid = 1'b1; rx_byte = 8'hE7; tick; rx_valid = 1'b0;
          go = 1'b0; ef = 1;
        end else begin
          get_tok(k, t); tr = t;
          chk("R5 response transmit", k, 1); chk("R5 R10 exec gap", t - tp, POLL_WIN + e + 3);
        end
      end else begin
        get_tok(k, t); tr = t;
        chk("R6 response transmit", k, 1); chk("R6 R10 short gap", t - tb, p + e + 2);
      end
    end
    if (go) begin
      nresp = 1;
      if (mode == 4) begin
        gap_ref = tr; gap_exp = RESP_TMO + 2; ef = 4;
      end else begin
        fails = 0;
        while (1) begin
          resp_done = 1'b1; resp_crc_ok = (fails >= nfail); tick; resp_done = 1'b0;
          if (fails >= nfail) break;
          fails++;
          if (fails > maxr) begin ef = 3; break; end
          get_tok(k, t); chk("R7 resend is transmit", k, 1); nresp++;
        end
        chk("R7 response requests", nresp, (nfail <= maxr) ? nfail + 1 : maxr + 1);
      end
    end
    get_tok(k, t); chk("R9 sleep last", k, 3);
    if (gap_exp >= 0) chk("R8 timeout gap", t - gap_ref, gap_exp);
    chk("R9 done pulse", int'(done), 1);
    chk("R9 idle at done", int'(busy), 0);
    chk("R4 dev_err", int'(dev_err), int'(ef == 1));
    chk("R3 sync_err", int'(sync_err), int'(ef == 2));
    chk("R7 retry_err", int'(retry_err), int'(ef == 3));
    chk("R8 tmo_err", int'(tmo_err), int'(ef == 4));
    if (ef == 1) chk("R4 err_byte", int'(err_byte), 8'hE7);
    tick;
    chk("R9 done one cycle", int'(done), 0);
    chk("R9 flags held", int'({dev_err, sync_err, retry_err, tmo_err}),
        (ef == 0) ? 0 : (1 << (4 - ef)));
    if (poke) begin
      repeat (5) tick;
      chk("R11 no new exchange", int'(busy | tok_req), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (3) tick;
    chk("R1 busy", int'(busy), 0);
    chk("R1 tok_req", int'(tok_req), 0);
    chk("R1 blk_go", int'(blk_go), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 flags", int'({dev_err, sync_err, retry_err, tmo_err}), 0);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 4; p++)
        for (int e = 0; e < 4; e++)
          run_txn(s[0], p, e, 0, 0, 1, 1'b0);
    run_txn(1'b0, 1, 1, 1, 0, 1, 1'b0);
    run_txn(1'b0, 1, 1, 2, 0, 1, 1'b0);
    run_txn(1'b0, 2, 1, 3, 0, 1, 1'b0);
    run_txn(1'b0, 1, 2, 4, 0, 1, 1'b0);
    run_txn(1'b1, 2, 0, 4, 0, 1, 1'b0);
    run_txn(1'b0, 0, 1, 0, 1, 1, 1'b0);
    run_txn(1'b1, 1, 0, 0, 2, 1, 1'b0);
    run_txn(1'b0, 1, 0, 0, 1, 0, 1'b0);
    run_txn(1'b1, 0, 2, 0, 3, 3, 1'b0);
    run_txn(1'b0, 3, 3, 0, 0, 2, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule